// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver

This block sits on the codec side of a serial audio link. It samples the frame-sync line and the serial data line on every falling edge of the bit clock. It locks onto each frame at a rising edge of the sync line and cuts the serial stream into one 16-bit tag and twelve 20-bit slots. The tag tells it which slots carry valid data and which codec the frame is addressed to. Each slot payload is placed in its own parallel register, and the register is overwritten only when the tag marks that slot valid.

The parallel side gives the decoded tag fields, the twelve slot registers and a command-valid flag. That flag is qualified by a codec ID that the integrator sets. A one-cycle strobe marks the end of each complete frame. A second one-cycle strobe reports a frame that a new sync edge cut short.

Top module: `aclink_frame_rx`

## Requirements
- R1: During reset and after it, every output is 0. This includes all slot registers, the tag fields, `frame_done` and `sync_error`.
- R2: A falling edge that samples `frame_sync` high, where the previous falling edge sampled it low, starts a frame. The first frame bit is sampled on the next falling edge. A sync line that stays high after the start does not restart the frame.
- R3: The 16 tag bits arrive MSB first, and the tag outputs update once tag bit 0 has been sampled. Tag bit 15 drives `frame_valid`. Tag bits 14 down to 3 drive `slot_valid[0]` (slot 1) through `slot_valid[11]` (slot 12). Bit 2 is ignored, and bits 1:0 drive `codec_id`.
- R4: Each slot is 20 bits, MSB first, and the slots follow the tag in order 1 to 12. Slot k lands in `slot_data[k-1]` once its last bit has been sampled.
- R5: A slot register is written only when both `frame_valid` and that slot's flag are 1 for the current frame. Otherwise it keeps its previous value.
- R6: `frame_done` is high for exactly one cycle, right after the falling edge that samples bit 255 of a frame.
- R7: A sync rising edge that comes before all 256 bits of a frame have been sampled does three things. It aborts the frame, pulses `sync_error` for one cycle without `frame_done`, and starts a new frame on that same edge. Slots completed before the abort keep their updates.
- R8: `cmd_valid` is 1 only when the current tag has `frame_valid`=1, the slot 1 flag =1, and `codec_id` equal to `my_id`. ID 0 denotes the primary codec, and 1 to 3 denote secondary codecs.
- R9: After a complete frame the receiver waits for a new sync rising edge. Serial data that arrives with sync low in that state changes no output and raises no `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all sampling and state use its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame sync line |
| ser_data | input | 1 | Serial frame data, MSB first |
| my_id | input | 2 | Codec ID this receiver answers to |
| frame_valid | output | 1 | Frame-valid bit of the latest tag |
| slot_valid | output | 12 | Per-slot valid flags, bit 0 = slot 1 |
| codec_id | output | 2 | Codec ID field of the latest tag |
| cmd_valid | output | 1 | Valid command addressed to this codec |
| slot_data | output | 240 | Twelve 20-bit slot registers, index 0 = slot 1 |
| frame_done | output | 1 | One-cycle strobe after a complete frame |
| sync_error | output | 1 | One-cycle strobe for a frame cut short by sync |

## Verification
The bench goes after several specific failures.

- **Bit alignment.** A receiver that takes the sync edge itself as bit 0 shifts every field by one place, so the tag and slot values compare wrong.
- **Sync held high.** Frames with sync held high for 1 to 40 bits catch a design that restarts on the sync level instead of its edge.
- **Aborts.** Frames are cut short inside the tag and inside slot 4. A design that fails to restart on the abort edge loses the next frame. A design that holds completed slots back until frame end shows stale slot registers.
- **Invalid frames and slots.** Frames with the frame-valid bit clear, and slots with their flag clear, expose a design that writes payloads anyway.
- **Idle data.** Random data sent with sync low after a frame exposes a receiver that keeps counting into a phantom frame.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;

    // Default frame geometry
    localparam int TAG_BITS_D  = 16;
    localparam int SLOT_BITS_D = 20;
    localparam int NUM_SLOTS_D = 12;
    localparam int ID_BITS_D   = 2;

    // Receiver phase
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_e;

    // Per-edge strobes from the aligner to the capture logic
    typedef struct packed {
        logic take;       // a frame bit is sampled on this edge
        logic tag_bit;    // sampled bit belongs to the tag
        logic tag_end;    // sampled bit is the last tag bit
        logic slot_bit;   // sampled bit belongs to a slot
        logic slot_end;   // sampled bit is the last bit of a slot
        logic frame_end;  // sampled bit is the last bit of the frame
    } rx_strobe_t;

    // Total frame length in bits
    function automatic int frame_len(input int tag_bits, input int slot_bits, input int num_slots);
        return tag_bits + slot_bits * num_slots;
    endfunction

endpackage

// File: rtl/aclink_sync_align.sv
module aclink_sync_align
    import aclink_rx_pkg::*;
#(
    parameter int TAG_BITS  = TAG_BITS_D,
    parameter int SLOT_BITS = SLOT_BITS_D,
    parameter int NUM_SLOTS = NUM_SLOTS_D,
    localparam int FRAME_BITS = frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS),
    localparam int CNT_W      = $clog2(FRAME_BITS + 1),
    localparam int IDX_W      = $clog2(NUM_SLOTS + 1),
    localparam int SB_W       = $clog2(SLOT_BITS)
) (
    input  logic             bit_clk,
    input  logic             rst,
    input  logic             frame_sync,
    output rx_strobe_t       stb,
    output logic [IDX_W-1:0] slot_sel,
    output logic             frame_done,
    output logic             sync_error
);

    rx_state_e        state;
    logic             sync_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [SB_W-1:0]  slot_bit_cnt;
    logic [IDX_W-1:0] slot_idx;
    logic             sync_rise;
    logic             in_frame;
    logic             in_tag;

    always_comb begin
        sync_rise     = frame_sync & ~sync_q;
        in_frame      = (state == RX_RECV);
        in_tag        = bit_cnt < CNT_W'(TAG_BITS);
        stb.take      = in_frame & ~sync_rise;
        stb.tag_bit   = stb.take & in_tag;
        stb.tag_end   = stb.take & (bit_cnt == CNT_W'(TAG_BITS - 1));
        stb.slot_bit  = stb.take & ~in_tag;
        stb.slot_end  = stb.slot_bit & (slot_bit_cnt == SB_W'(SLOT_BITS - 1));
        stb.frame_end = stb.take & (bit_cnt == CNT_W'(FRAME_BITS - 1));
        slot_sel      = slot_idx;
    end

    always_ff @(negedge bit_clk) begin
        if (rst) begin
            state        <= RX_IDLE;
            sync_q       <= 1'b0;
            bit_cnt      <= '0;
            slot_bit_cnt <= '0;
            slot_idx     <= '0;
            frame_done   <= 1'b0;
            sync_error   <= 1'b0;
        end else begin
            sync_q     <= frame_sync;
            frame_done <= stb.frame_end;
            sync_error <= sync_rise & in_frame;
            if (sync_rise) begin
                state        <= RX_RECV;
                bit_cnt      <= '0;
                slot_bit_cnt <= '0;
                slot_idx     <= '0;
            end else if (stb.take) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (stb.frame_end) begin
                    state <= RX_IDLE;
                end
                if (stb.slot_bit) begin
                    if (stb.slot_end) begin
                        slot_bit_cnt <= '0;
                        slot_idx     <= slot_idx + 1'b1;
                    end else begin
                        slot_bit_cnt <= slot_bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_CNT_IN_FRAME: assert property (@(negedge bit_clk) disable iff (rst)
        in_frame |-> (bit_cnt < CNT_W'(FRAME_BITS))); // R6
    AST_DONE_ONE_CYCLE: assert property (@(negedge bit_clk) disable iff (rst)
        frame_done |=> !frame_done); // R6
    AST_DONE_LEAVES_FRAME: assert property (@(negedge bit_clk) disable iff (rst)
        frame_done |-> !in_frame || sync_q); // R9
    AST_ERROR_FROM_SYNC: assert property (@(negedge bit_clk) disable iff (rst)
        sync_error |-> $past(frame_sync)); // R7
    AST_ERROR_NOT_DONE: assert property (@(negedge bit_clk) disable iff (rst)
        !(sync_error && frame_done)); // R7

endmodule

// File: rtl/aclink_tag_decode.sv
module aclink_tag_decode
    import aclink_rx_pkg::*;
#(
    parameter int TAG_BITS  = TAG_BITS_D,
    parameter int NUM_SLOTS = NUM_SLOTS_D,
    parameter int ID_BITS   = ID_BITS_D
) (
    input  logic                 bit_clk,
    input  logic                 rst,
    input  rx_strobe_t           stb,
    input  logic                 din,
    input  logic [ID_BITS-1:0]   my_id,
    output logic                 frame_valid,
    output logic [NUM_SLOTS-1:0] slot_valid,
    output logic [ID_BITS-1:0]   codec_id,
    output logic                 cmd_valid
);

    localparam int FV_POS = TAG_BITS - 1;

    logic [TAG_BITS-2:0]  tag_sh;
    logic [TAG_BITS-1:0]  tag_word;
    logic [NUM_SLOTS-1:0] flags;

    always_comb begin
        tag_word = {tag_sh, din};
        for (int k = 0; k < NUM_SLOTS; k++) begin
            flags[k] = tag_word[FV_POS - 1 - k];
        end
    end

    always_ff @(negedge bit_clk) begin
        if (rst) begin
            tag_sh      <= '0;
            frame_valid <= 1'b0;
            slot_valid  <= '0;
            codec_id    <= '0;
            cmd_valid   <= 1'b0;
        end else begin
            if (stb.tag_bit) begin
                tag_sh <= tag_word[TAG_BITS-2:0];
            end
            if (stb.tag_end) begin
                frame_valid <= tag_word[FV_POS];
                slot_valid  <= flags;
                codec_id    <= tag_word[ID_BITS-1:0];
                cmd_valid   <= tag_word[FV_POS] & flags[0] &
                               (tag_word[ID_BITS-1:0] == my_id);
            end
        end
    end

    AST_CMD_NEEDS_FLAGS: assert property (@(negedge bit_clk) disable iff (rst)
        cmd_valid |-> frame_valid && slot_valid[0]); // R8
    AST_TAG_ONLY_AT_END: assert property (@(negedge bit_clk) disable iff (rst)
        !stb.tag_end |=> $stable(codec_id) && $stable(slot_valid)); // R3

endmodule

// File: rtl/aclink_slot_capture.sv
module aclink_slot_capture
    import aclink_rx_pkg::*;
#(
    parameter int SLOT_BITS = SLOT_BITS_D,
    parameter int NUM_SLOTS = NUM_SLOTS_D,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic                                bit_clk,
    input  logic                                rst,
    input  rx_strobe_t                          stb,
    input  logic [IDX_W-1:0]                    slot_sel,
    input  logic                                din,
    input  logic                                frame_valid,
    input  logic [NUM_SLOTS-1:0]                slot_valid,
    output logic [NUM_SLOTS-1:0][SLOT_BITS-1:0] slot_data
);

    logic [SLOT_BITS-2:0] slot_sh;
    logic [SLOT_BITS-1:0] slot_word;

    assign slot_word = {slot_sh, din};

    always_ff @(negedge bit_clk) begin
        if (rst) begin
            slot_sh <= '0;
        end else if (stb.slot_bit) begin
            slot_sh <= slot_word[SLOT_BITS-2:0];
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic wr_en;
        assign wr_en = stb.slot_end && (slot_sel == IDX_W'(g)) &&
                       frame_valid && slot_valid[g];

        always_ff @(negedge bit_clk) begin
            if (rst) begin
                slot_data[g] <= '0;
            end else if (wr_en) begin
                slot_data[g] <= slot_word;
            end
        end

        AST_SLOT_WRITE_GATED: assert property (@(negedge bit_clk) disable iff (rst)
            !$stable(slot_data[g]) |-> $past(frame_valid && slot_valid[g])); // R5
    end

endmodule

// File: rtl/aclink_frame_rx.sv
module aclink_frame_rx
    import aclink_rx_pkg::*;
#(
    parameter int TAG_BITS  = TAG_BITS_D,
    parameter int SLOT_BITS = SLOT_BITS_D,
    parameter int NUM_SLOTS = NUM_SLOTS_D,
    parameter int ID_BITS   = ID_BITS_D
) (
    input  logic                                bit_clk,
    input  logic                                rst,
    input  logic                                frame_sync,
    input  logic                                ser_data,
    input  logic [ID_BITS-1:0]                  my_id,
    output logic                                frame_valid,
    output logic [NUM_SLOTS-1:0]                slot_valid,
    output logic [ID_BITS-1:0]                  codec_id,
    output logic                                cmd_valid,
    output logic [NUM_SLOTS-1:0][SLOT_BITS-1:0] slot_data,
    output logic                                frame_done,
    output logic                                sync_error
);

    localparam int IDX_W = $clog2(NUM_SLOTS + 1);

    rx_strobe_t       stb;
    logic [IDX_W-1:0] slot_sel;

    aclink_sync_align #(
        .TAG_BITS (TAG_BITS),
        .SLOT_BITS(SLOT_BITS),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_align (
        .bit_clk   (bit_clk),
        .rst       (rst),
        .frame_sync(frame_sync),
        .stb       (stb),
        .slot_sel  (slot_sel),
        .frame_done(frame_done),
        .sync_error(sync_error)
    );

    aclink_tag_decode #(
        .TAG_BITS (TAG_BITS),
        .NUM_SLOTS(NUM_SLOTS),
        .ID_BITS  (ID_BITS)
    ) u_tag (
        .bit_clk    (bit_clk),
        .rst        (rst),
        .stb        (stb),
        .din        (ser_data),
        .my_id      (my_id),
        .frame_valid(frame_valid),
        .slot_valid (slot_valid),
        .codec_id   (codec_id),
        .cmd_valid  (cmd_valid)
    );

    aclink_slot_capture #(
        .SLOT_BITS(SLOT_BITS),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_slots (
        .bit_clk    (bit_clk),
        .rst        (rst),
        .stb        (stb),
        .slot_sel   (slot_sel),
        .din        (ser_data),
        .frame_valid(frame_valid),
        .slot_valid (slot_valid),
        .slot_data  (slot_data)
    );

    AST_RESET_QUIET: assert property (@(negedge bit_clk)
        $past(rst) |-> !frame_done && !sync_error); // R1

endmodule

// File: tb/aclink_frame_rx_tb.sv
module aclink_frame_rx_tb;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 fsync;
    logic                 sdat;
    logic [1:0]           my_id;
    logic                 frame_valid;
    logic [11:0]          slot_valid;
    logic [1:0]           codec_id;
    logic                 cmd_valid;
    logic [11:0][19:0]    slot_data;
    logic                 frame_done;
    logic                 sync_error;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [19:0] pay   [12];
    logic [19:0] exp_q [12];
    logic [15:0] exp_tag;

    always #10 clk = ~clk;

    aclink_frame_rx u_dut (
        .bit_clk    (clk),
        .rst        (rst),
        .frame_sync (fsync),
        .ser_data   (sdat),
        .my_id      (my_id),
        .frame_valid(frame_valid),
        .slot_valid (slot_valid),
        .codec_id   (codec_id),
        .cmd_valid  (cmd_valid),
        .slot_data  (slot_data),
        .frame_done (frame_done),
        .sync_error (sync_error)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Sample point between a falling edge and the next rising edge
    task automatic settle();
        @(negedge clk);
        #5;
    endtask

    function automatic logic frame_bit(input logic [15:0] tag, input int i);
        int s;
        if (i < 16) return tag[15 - i];
        s = (i - 16) / 20;
        return pay[s][19 - ((i - 16) % 20)];
    endfunction

    // Drive a frame; stop_at < 256 leaves it unfinished
    task automatic drive_frame(input logic [15:0] tag, input int sync_len,
                               input int stop_at, input bit skip_start);
        if (!skip_start) begin
            @(posedge clk);
            fsync = 1'b1;
            sdat  = 1'b0;
        end
        for (int i = 0; i < stop_at; i++) begin
            @(posedge clk);
            fsync = (i < sync_len - 1);
            sdat  = frame_bit(tag, i);
        end
        if (stop_at >= 16) exp_tag = tag;
        for (int s = 0; s < 12; s++) begin
            if (stop_at >= 16 && tag[15] && tag[14 - s] && (36 + 20 * s <= stop_at))
                exp_q[s] = pay[s];
        end
    endtask

    task automatic check_outputs(input string req);
        logic [11:0] ev;
        for (int s = 0; s < 12; s++) ev[s] = exp_tag[14 - s];
        check(frame_valid == exp_tag[15], "R3", "frame_valid", 32'(frame_valid), 32'(exp_tag[15]));
        check(slot_valid == ev, "R3", "slot_valid", 32'(slot_valid), 32'(ev));
        check(codec_id == exp_tag[1:0], "R3", "codec_id", 32'(codec_id), 32'(exp_tag[1:0]));
        check(cmd_valid == (exp_tag[15] && exp_tag[14] && exp_tag[1:0] == my_id), "R8",
              "cmd_valid", 32'(cmd_valid),
              32'(exp_tag[15] && exp_tag[14] && exp_tag[1:0] == my_id));
        for (int s = 0; s < 12; s++)
            check(slot_data[s] == exp_q[s], req, $sformatf("slot%0d", s + 1),
                  32'(slot_data[s]), 32'(exp_q[s]));
    endtask

    task automatic full_frame(input logic [15:0] tag, input int sync_len, input string req);
        drive_frame(tag, sync_len, 256, 0);
        settle();
        check(frame_done == 1'b1, "R6", "frame_done high", 32'(frame_done), 32'd1);
        check(sync_error == 1'b0, "R7", "no sync_error", 32'(sync_error), 32'd0);
        check_outputs(req);
        settle();
        check(frame_done == 1'b0, "R6", "frame_done one cycle", 32'(frame_done), 32'd0);
    endtask

    task automatic new_payload();
        for (int s = 0; s < 12; s++) pay[s] = 20'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        rst = 1'b1; fsync = 1'b0; sdat = 1'b0; my_id = 2'd0;
        for (int s = 0; s < 12; s++) exp_q[s] = '0;
        exp_tag = '0;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        settle();
        // R1 reset state
        check(frame_done == 0 && sync_error == 0, "R1", "strobes after reset",
              {30'd0, frame_done, sync_error}, 32'd0);
        check_outputs("R1");

        // R2/R4 all slots valid, primary codec, sync held 16 bits
        new_payload();
        full_frame(16'hFFF8, 16, "R4");

        // R2 sync high only at the start edge, then held 40 bits
        new_payload();
        full_frame(16'hAAA8, 1, "R2");
        new_payload();
        full_frame(16'hD558, 40, "R2");

        // R5 frame_valid clear: nothing written
        new_payload();
        full_frame(16'h7FF8, 16, "R5");

        // R8 ID mismatch and match for a secondary codec
        my_id = 2'd2;
        new_payload();
        full_frame(16'hC001, 16, "R8");
        new_payload();
        full_frame(16'hC002, 16, "R8");

        // R9 random data with sync low after a frame
        begin
            bit saw_done = 0;
            for (int c = 0; c < 300; c++) begin
                @(posedge clk);
                fsync = 1'b0;
                sdat  = 1'($urandom);
                settle();
                if (frame_done || sync_error) saw_done = 1;
            end
            check(!saw_done, "R9", "no strobe while idle", 32'(saw_done), 32'd0);
            check_outputs("R9");
        end

        // R7 abort inside slot 4, then invalid frame keeps partial updates
        new_payload();
        drive_frame(16'hFFF8, 16, 83, 0);
        @(posedge clk);
        fsync = 1'b1; sdat = 1'b0;
        settle();
        check(sync_error == 1'b1, "R7", "sync_error on abort", 32'(sync_error), 32'd1);
        check(frame_done == 1'b0, "R7", "no frame_done on abort", 32'(frame_done), 32'd0);
        for (int s = 0; s < 12; s++)
            check(slot_data[s] == exp_q[s], "R7", $sformatf("partial slot%0d", s + 1),
                  32'(slot_data[s]), 32'(exp_q[s]));
        new_payload();
        drive_frame(16'h0000, 16, 256, 1);
        settle();
        check(frame_done == 1'b1, "R7", "restarted frame completes", 32'(frame_done), 32'd1);
        check_outputs("R7");
        settle();
        check(sync_error == 1'b0, "R7", "sync_error one cycle", 32'(sync_error), 32'd0);

        // R7 abort inside the tag
        new_payload();
        drive_frame(16'h8008, 4, 10, 0);
        @(posedge clk);
        fsync = 1'b1; sdat = 1'b0;
        settle();
        check(sync_error == 1'b1, "R7", "sync_error in tag", 32'(sync_error), 32'd1);
        check_outputs("R7");
        new_payload();
        drive_frame(16'hBFF9, 16, 256, 1);
        settle();
        check(frame_done == 1'b1, "R7", "frame after tag abort", 32'(frame_done), 32'd1);
        check_outputs("R5");
        settle();

        // Random frames
        for (int n = 0; n < 24; n++) begin
            logic [15:0] t;
            my_id = 2'($urandom);
            t = 16'($urandom);
            if (($urandom % 4) != 0) t[15] = 1'b1;
            new_payload();
            full_frame(t, 1 + int'($urandom % 30), "R4");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule